// File: doc/BRIEF.md
# Damped Sliding Single-Bin Spectral Filter

This block tracks one frequency bin of a real sample stream over a sliding window of the most recent `WIN_N` samples. Each new sample updates the bin without redoing the whole transform. The structure has two stages. A comb stage removes the sample that has just left the window. A complex resonator then rotates the running bin value by one bin step.

The comb weights the departing sample by gamma^N. The resonator weights its feedback by gamma. This small damping, just below one, stops rounding residue from building up in the recursive path. A one-sample register between the comb and the resonator gives the in-phase output the correct phase relative to the input fundamental.

The two outputs are the real (in-phase) and imaginary (quadrature) parts of the bin. At the bin frequency they are 90 degrees apart, and they feed a phase detector further along the chain. The bin position, the window length and the damping are fixed when the block is built. They are encoded in three Q1.15 coefficients.

Top module: `sdft_bin`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_re` and `out_im` are 0. The delay line, comb register and resonator state are also cleared.
- R2: For each accepted sample x, the comb value is c = x - round(COEF_COMB * x_old / 2^15), where x_old is the sample accepted `WIN_N` samples earlier. The default COEF_COMB is 32119.
- R3: The resonator adds the comb value of the previous accepted sample, not the current one. After reset, an impulse therefore leaves both outputs at 0 on its own update and shows up in `out_re` on the following accepted sample.
- R4: On each accepted sample, the new state is re' = sat(round(C*re - S*im) + c_prev) and im' = sat(round(S*re + C*im)). The defaults are C = 26483 and S = 19241, which is about 0.999 times the cosine and sine of 2*pi*2/20.
- R5: Rounding adds 2^14 and then shifts arithmetically right by 15 bits, so exact halves round toward positive infinity.
- R6: Each resonator result is saturated to the signed range of `STATE_W` bits rather than wrapping.
- R7: A cycle without `in_valid` leaves `out_re`, `out_im` and the window contents unchanged.
- R8: `out_valid` pulses for one cycle, in the cycle after an accepted sample. It pulses only once at least `WIN_N` samples have been accepted since reset.
- R9: Until `WIN_N` samples have been accepted, x_old reads as 0. After that, it is exactly the sample accepted `WIN_N` samples earlier, with no count for idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Bin update strobe, after the window has filled |
| out_re | output | STATE_W | Signed in-phase (real) bin value |
| out_im | output | STATE_W | Signed quadrature (imaginary) bin value |

## Verification
A single impulse shows that the comb result is delayed by one sample before the resonator uses it. It also shows the impulse coming back, negated and scaled by the comb coefficient, exactly `WIN_N` samples later. A DC level fed with idle gaps checks that empty cycles do not advance the window or disturb the state.

An on-bin tone and an off-bin tone exercise the rotation and its rounding with different spectra. A full-scale on-bin tone, run with a narrow state width, drives the resonator into saturation. A pseudo-random stream with random strobe gaps compares the whole state path against an integer model every clock.

// File: rtl/sdft_pkg.sv
package sdft_pkg;
  localparam int unsigned Q_FRAC   = 15;
  localparam int unsigned Q_COEF_W = 16;
endpackage

// File: rtl/sdft_delay_line.sv
module sdft_delay_line #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout_old
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic signed [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]         ptr_q;
  logic [PTR_W-1:0]         ptr_d;

  always_comb begin
    if (ptr_q == PTR_W'(DEPTH - 1)) ptr_d = '0;
    else                            ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[ptr_q] <= din;
      ptr_q        <= ptr_d;
    end
  end

  // Slot about to be overwritten holds the sample from DEPTH writes ago.
  assign dout_old = mem_q[ptr_q];
endmodule

// File: rtl/sdft_comb.sv
module sdft_comb
  import sdft_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned COMB_W    = 18,
  parameter int          COEF_COMB = 32119
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] x_new,
  input  logic signed [DATA_W-1:0] x_old,
  output logic signed [COMB_W-1:0] comb_q
);
  localparam int unsigned P_W = DATA_W + Q_COEF_W;
  localparam logic signed [Q_COEF_W-1:0] K_C  = Q_COEF_W'(COEF_COMB);
  localparam logic signed [P_W-1:0]      HALF = P_W'(1) << (Q_FRAC - 1);

  logic signed [P_W-1:0]    prod;
  logic signed [P_W-1:0]    rnd;
  logic signed [COMB_W-1:0] comb_d;

  always_comb begin
    prod   = K_C * x_old;
    rnd    = (prod + HALF) >>> Q_FRAC;
    comb_d = COMB_W'(x_new) - COMB_W'(rnd);
  end

  // Unit delay between comb and resonator.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  comb_q <= '0;
    else if (en) comb_q <= comb_d;
  end
endmodule

// File: rtl/sdft_resonator.sv
module sdft_resonator
  import sdft_pkg::*;
#(
  parameter int unsigned COMB_W  = 18,
  parameter int unsigned STATE_W = 24,
  parameter int          COEF_RE = 26483,
  parameter int          COEF_IM = 19241
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic signed [COMB_W-1:0]  comb_in,
  output logic signed [STATE_W-1:0] re_q,
  output logic signed [STATE_W-1:0] im_q
);
  localparam int unsigned P_W = STATE_W + Q_COEF_W + 1;
  localparam logic signed [Q_COEF_W-1:0] K_RE = Q_COEF_W'(COEF_RE);
  localparam logic signed [Q_COEF_W-1:0] K_IM = Q_COEF_W'(COEF_IM);
  localparam logic signed [P_W-1:0] HALF = P_W'(1) << (Q_FRAC - 1);
  localparam logic signed [P_W-1:0] MAXV = P_W'({1'b0, {(STATE_W-1){1'b1}}});
  localparam logic signed [P_W-1:0] MINV = -MAXV - P_W'(1);

  logic signed [P_W-1:0]     acc_re, acc_im, sum_re, sum_im;
  logic signed [STATE_W-1:0] re_d, im_d;

  function automatic logic signed [STATE_W-1:0] clip(input logic signed [P_W-1:0] v);
    if (v > MAXV)      clip = STATE_W'(MAXV);
    else if (v < MINV) clip = STATE_W'(MINV);
    else               clip = STATE_W'(v);
  endfunction

  always_comb begin
    acc_re = P_W'(K_RE * re_q) - P_W'(K_IM * im_q);
    acc_im = P_W'(K_IM * re_q) + P_W'(K_RE * im_q);
    sum_re = ((acc_re + HALF) >>> Q_FRAC) + P_W'(comb_in);
    sum_im = (acc_im + HALF) >>> Q_FRAC;
    re_d   = clip(sum_re);
    im_d   = clip(sum_im);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_q <= '0;
      im_q <= '0;
    end else if (en) begin
      re_q <= re_d;
      im_q <= im_d;
    end
  end
endmodule

// File: rtl/sdft_bin.sv
module sdft_bin
  import sdft_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STATE_W   = 24,
  parameter int unsigned WIN_N     = 20,
  parameter int          COEF_RE   = 26483,
  parameter int          COEF_IM   = 19241,
  parameter int          COEF_COMB = 32119
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic signed [DATA_W-1:0]  in_sample,
  output logic                      out_valid,
  output logic signed [STATE_W-1:0] out_re,
  output logic signed [STATE_W-1:0] out_im
);
  localparam int unsigned COMB_W = DATA_W + 2;
  localparam int unsigned CNT_W  = $clog2(WIN_N + 1);

  logic signed [DATA_W-1:0] x_old;
  logic signed [COMB_W-1:0] comb_q;
  logic [CNT_W-1:0]         fill_q, fill_d;
  logic                     vld_d;

  sdft_delay_line #(.DATA_W(DATA_W), .DEPTH(WIN_N)) i_dly (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .din(in_sample), .dout_old(x_old)
  );

  sdft_comb #(.DATA_W(DATA_W), .COMB_W(COMB_W), .COEF_COMB(COEF_COMB)) i_comb (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .x_new(in_sample), .x_old(x_old),
    .comb_q(comb_q)
  );

  sdft_resonator #(.COMB_W(COMB_W), .STATE_W(STATE_W),
                   .COEF_RE(COEF_RE), .COEF_IM(COEF_IM)) i_res (
    .clk(clk), .rst_n(rst_n), .en(in_valid), .comb_in(comb_q),
    .re_q(out_re), .im_q(out_im)
  );

  always_comb begin
    fill_d = fill_q;
    if (in_valid && (fill_q != CNT_W'(WIN_N))) fill_d = fill_q + 1'b1;
    vld_d = in_valid && (fill_q >= CNT_W'(WIN_N - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q    <= '0;
      out_valid <= 1'b0;
    end else begin
      fill_q    <= fill_d;
      out_valid <= vld_d;
    end
  end
endmodule

// File: rtl/sdft_bin_chk.sv
module sdft_bin_chk #(
  parameter int unsigned WIN_N   = 20,
  parameter int unsigned STATE_W = 24
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      out_valid,
  input logic signed [STATE_W-1:0] out_re,
  input logic signed [STATE_W-1:0] out_im
);
  int unsigned seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          seen_q <= 0;
    else if (in_valid && seen_q < WIN_N) seen_q <= seen_q + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!out_valid && out_re == '0 && out_im == '0); // R1
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_re) && $stable(out_im))); // R7

  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R8

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seen_q >= WIN_N)); // R8
endmodule

bind sdft_bin sdft_bin_chk #(.WIN_N(WIN_N), .STATE_W(STATE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_re(out_re), .out_im(out_im)
);

// File: tb/test_sdft_bin.sv
module test_sdft_bin;
  localparam int DW = 16;
  localparam int SW = 18;
  localparam int N  = 20;
  localparam longint C_RE = 26483;
  localparam longint C_IM = 19241;
  localparam longint C_CB = 32119;
  localparam longint SMAX = (64'sd1 <<< (SW - 1)) - 1;
  localparam longint SMIN = -(64'sd1 <<< (SW - 1));
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [DW-1:0] in_sample;
  logic out_valid;
  logic signed [SW-1:0] out_re, out_im;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  longint hist[$];
  longint m_re, m_im, m_cq;
  int     m_cnt;
  bit     m_vld;

  always #10 clk = ~clk;

  sdft_bin #(.DATA_W(DW), .STATE_W(SW), .WIN_N(N)) i_sdft_bin (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  function automatic longint rnd15(input longint v);
    return (v + 16384) >>> 15; // R5
  endfunction

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic model_clear();
    hist.delete();
    m_re = 0; m_im = 0; m_cq = 0; m_cnt = 0; m_vld = 0;
  endtask

  task automatic model_sample(input longint x);
    longint xo, c, nre, nim;
    xo  = (hist.size() >= N) ? hist[hist.size() - N] : 0;      // R9
    hist.push_back(x);
    c   = x - rnd15(C_CB * xo);                                // R2
    nre = sat(rnd15(C_RE * m_re - C_IM * m_im) + m_cq);        // R3 R4 R6
    nim = sat(rnd15(C_IM * m_re + C_RE * m_im));
    m_re = nre; m_im = nim; m_cq = c;
    if (m_cnt < N) m_cnt++;
    m_vld = (m_cnt >= N);                                      // R8
  endtask

  task automatic compare(input string tag);
    checks++;
    if (out_valid !== m_vld) begin
      errors++;
      $display("FAIL R8 (%s) out_valid=%0b expected %0b", tag, out_valid, m_vld);
    end
    checks++;
    if (longint'(out_re) != m_re) begin
      errors++;
      $display("FAIL %s out_re=%0d expected %0d", tag, out_re, m_re);
    end
    checks++;
    if (longint'(out_im) != m_im) begin
      errors++;
      $display("FAIL %s out_im=%0d expected %0d", tag, out_im, m_im);
    end
  endtask

  task automatic step(input bit v, input longint x, input string tag);
    @(negedge clk);
    compare(tag);
    in_valid  = v;
    in_sample = DW'(x);
    if (v) model_sample(x);
    else   m_vld = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    model_clear();
    @(negedge clk);
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit [31:0] s;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    model_clear();
    // R1: reset state
    do_reset();

    // R3, R9, R2: impulse, its delayed appearance and its return after N
    step(1, 1000, "R3");
    step(1, 0, "R3");
    step(1, 0, "R3");
    for (int i = 0; i < 40; i++) step(1, 0, "R9");
    step(0, 0, "R2");

    // R7: DC level with idle gaps
    do_reset();
    for (int i = 0; i < 90; i++) step((i % 3) != 2, 5000, "R7");

    // R4: on-bin tone (period 10 samples)
    do_reset();
    for (int i = 0; i < 80; i++)
      step(1, longint'($rtoi(8000.0 * $cos(2.0 * PI * i / 10.0))), "R4");

    // R4: off-bin tone (period 7 samples)
    do_reset();
    for (int i = 0; i < 80; i++)
      step(1, longint'($rtoi(9000.0 * $sin(2.0 * PI * i / 7.0))), "R4");

    // R6: full-scale on-bin tone drives the state into saturation
    do_reset();
    for (int i = 0; i < 120; i++)
      step(1, longint'($rtoi(32767.0 * $cos(2.0 * PI * i / 10.0))), "R6");

    // R5: pseudo-random data with random strobe gaps
    do_reset();
    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      step(s[3:0] != 4'd0, longint'($signed(s[30:15])), "R5");
    end
    step(0, 0, "R5");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule